// File: doc/BRIEF.md
# Quad-rate burst memory with shared address bus

This block is an on-chip memory with one write data port and one read data port, both fed from a single address bus. The bus carries a read address and a write address in turn. An internal slot bit alternates every clock. On a read-slot edge the bus is taken as a read address. On a write-slot edge it is taken as a write address. Each address names a line of four data words, and every access moves the whole line as a burst.

Double-rate transfer is folded into one clock domain. Each port moves two words per clock, so a four-word burst takes two consecutive cycles on that port. Write data follows its address by one cycle. Read data appears on the read port after a fixed two-cycle latency, and a valid flag marks the two output cycles.

A read that lands while a write to the same line is still going in returns the newest bytes. This holds word pair by word pair and byte lane by byte lane.

Top module: `qdr_burst_mem`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rd_valid` is 0 and `wr_slot` is 0.
- R2: `wr_slot` toggles every clock after reset. On an edge with `wr_slot`=0, only `rd_sel_n` is honoured and `addr` is a read address. On an edge with `wr_slot`=1, only `wr_sel_n` is honoured and `addr` is a write address. A select asserted in the other slot has no effect.
- R3: A read-slot edge with `rd_sel_n`=1 starts no read, and no `rd_valid` pulse results from it.
- R4: A write-slot edge with `wr_sel_n`=1 changes no stored word, whatever is driven on the write data inputs afterwards.
- R5: After a write address is taken on edge E, two things happen. `wd0`/`wd1` sampled on edge E+1 become words 0 and 1 of that line. `wd0`/`wd1` sampled on edge E+2 become words 2 and 3. Words use offsets 0..3 in order, with no wrap or interleave.
- R6: Bit i of `wbe0` (or `wbe1`) enables bits 8i+7..8i of `wd0` (or `wd1`). A deasserted enable leaves that byte of the stored word unchanged.
- R7: After a read address is taken on edge R, two output pairs follow. Words 0 and 1 of the line are on `rd0`/`rd1` during the cycle after edge R+2. Words 2 and 3 are there during the cycle after edge R+3.
- R8: `rd_valid` is 1 exactly during the two output cycles of each read and 0 otherwise.
- R9: A read word pair launched on the same edge that commits a write to that line and pair returns the newly written bytes for enabled lanes. It returns the stored bytes for the other lanes.
- R10: Reads taken on every read slot give an unbroken run of output words with `rd_valid` held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Shared line address, read or write according to the slot |
| rd_sel_n | input | 1 | Active-low read request, honoured in read slots |
| wr_sel_n | input | 1 | Active-low write request, honoured in write slots |
| wr_slot | output | 1 | 0: the coming edge is a read slot; 1: a write slot |
| wd0 | input | 8*LANES | Write word, even beat |
| wd1 | input | 8*LANES | Write word, odd beat |
| wbe0 | input | LANES | Byte enables for `wd0` |
| wbe1 | input | LANES | Byte enables for `wd1` |
| rd0 | output | 8*LANES | Read word, even beat |
| rd1 | output | 8*LANES | Read word, odd beat |
| rd_valid | output | 1 | High while `rd0`/`rd1` carry read data |

## Verification
A read launch and a write commit can land on the same edge for the same line and word pair. The bench provokes this in two ways. In the directed case, a read is issued and a write to the same line follows in the very next slot. In the random phase, both selects are held active on nearly every cycle over only four lines, with random byte enables. A reference array takes each write pair on the edge that commits it. The monitor compares every output pair against that array half a cycle after the launch edge, so an output holding stale bytes where new ones were enabled is reported.

// File: rtl/qdrb_pkg.sv
// Shared constants and types for the quad-rate burst memory.
package qdrb_pkg;
    localparam int unsigned BURST_LEN     = 4;
    localparam int unsigned BEATS_PER_CLK = 2;
    localparam int unsigned HALVES        = BURST_LEN / BEATS_PER_CLK;

    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;
endpackage

// File: rtl/qdrb_req_ctl.sv
// Request slotting: keeps the read/write slot bit and qualifies the two
// active-low selects with it.
// Assumes: reset places the first active edge in the read slot.
module qdrb_req_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_sel_n,
    input  logic wr_sel_n,
    output logic slot_o,
    output logic rd_take,
    output logic wr_take
);
    import qdrb_pkg::*;

    slot_e slot_q;

    // Alternate read and write slots on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= SLOT_RD;
        else
            slot_q <= (slot_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
    end

    // A select only counts in its own slot.
    always_comb begin
        rd_take = (slot_q == SLOT_RD) && !rd_sel_n;
        wr_take = (slot_q == SLOT_WR) && !wr_sel_n;
        slot_o  = slot_q;
    end
endmodule

// File: rtl/qdrb_wr_seq.sv
// Write sequencer: holds a taken write address and commits word pair 0
// one edge later and pair 1 on the edge after that.
// Assumes: write takes are at least two edges apart (slotting guarantees it).
module qdrb_wr_seq #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_take,
    input  logic [AW-1:0] addr,
    output logic          cm_en,
    output logic [AW-1:0] cm_addr,
    output logic          cm_half
);
    logic          h0_pend, h1_pend;
    logic [AW-1:0] h0_addr, h1_addr;

    // Pending flags: first half follows the take, second half follows the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h0_pend <= 1'b0;
            h1_pend <= 1'b0;
        end else begin
            h0_pend <= wr_take;
            h1_pend <= h0_pend;
        end
    end

    // Address staging for both halves.
    always_ff @(posedge clk) begin
        if (wr_take) h0_addr <= addr;
        if (h0_pend) h1_addr <= h0_addr;
    end

    // Present the commit for the half that is due on the coming edge.
    always_comb begin
        cm_en   = h0_pend | h1_pend;
        cm_half = h1_pend;
        cm_addr = h1_pend ? h1_addr : h0_addr;
    end
endmodule

// File: rtl/qdrb_rd_pipe.sv
// Read latency pipeline: delays a taken read address so that word pair 0
// is launched on the second edge after the take and pair 1 on the third.
// Assumes: read takes are at least two edges apart.
module qdrb_rd_pipe #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_take,
    input  logic [AW-1:0] addr,
    output logic          ln_en,
    output logic [AW-1:0] ln_addr,
    output logic          ln_half
);
    logic          a_v, b_v, c_v;
    logic [AW-1:0] a_addr, b_addr, c_addr;

    // Stage valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_v <= 1'b0;
            b_v <= 1'b0;
            c_v <= 1'b0;
        end else begin
            a_v <= rd_take;
            b_v <= a_v;
            c_v <= b_v;
        end
    end

    // Stage addresses.
    always_ff @(posedge clk) begin
        if (rd_take) a_addr <= addr;
        if (a_v)     b_addr <= a_addr;
        if (b_v)     c_addr <= b_addr;
    end

    // Launch pair 0 from stage b, pair 1 from stage c (never both at once).
    always_comb begin
        ln_en   = b_v | c_v;
        ln_half = c_v;
        ln_addr = c_v ? c_addr : b_addr;
    end
endmodule

// File: rtl/qdrb_store.sv
// Line store: word array with a two-word byte-masked write port and a
// two-word read port. The read forwards the write committed on the same
// edge and registers the result on the outputs.
// Assumes: LANES byte lanes per word; the array itself has no reset.
module qdrb_store #(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cm_en,
    input  logic [AW-1:0]      cm_addr,
    input  logic               cm_half,
    input  logic [8*LANES-1:0] wd0,
    input  logic [8*LANES-1:0] wd1,
    input  logic [LANES-1:0]   wbe0,
    input  logic [LANES-1:0]   wbe1,
    input  logic               ln_en,
    input  logic [AW-1:0]      ln_addr,
    input  logic               ln_half,
    output logic [8*LANES-1:0] rd0,
    output logic [8*LANES-1:0] rd1,
    output logic               rd_valid
);
    import qdrb_pkg::*;

    localparam int unsigned DW    = 8 * LANES;
    localparam int unsigned WORDS = (1 << AW) * BURST_LEN;

    logic [DW-1:0]    mem   [WORDS];
    logic [DW-1:0]    wd    [BEATS_PER_CLK];
    logic [LANES-1:0] wbe   [BEATS_PER_CLK];
    logic [DW-1:0]    rword [BEATS_PER_CLK];
    logic             hit;

    assign wd[0]  = wd0;
    assign wd[1]  = wd1;
    assign wbe[0] = wbe0;
    assign wbe[1] = wbe1;

    // Byte-masked write of the committed word pair.
    always_ff @(posedge clk) begin
        if (cm_en) begin
            for (int k = 0; k < BEATS_PER_CLK; k++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wbe[k][l])
                        mem[{cm_addr, cm_half, 1'(k)}][l*8 +: 8] <= wd[k][l*8 +: 8];
                end
            end
        end
    end

    // Same line and pair being written on this edge.
    assign hit = cm_en && (cm_addr == ln_addr) && (cm_half == ln_half);

    // Read the launched pair and merge any enabled bytes written on this edge.
    always_comb begin
        for (int k = 0; k < BEATS_PER_CLK; k++) begin
            rword[k] = mem[{ln_addr, ln_half, 1'(k)}];
            for (int l = 0; l < LANES; l++) begin
                if (hit && wbe[k][l])
                    rword[k][l*8 +: 8] = wd[k][l*8 +: 8];
            end
        end
    end

    // Output registers and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd0      <= '0;
            rd1      <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= ln_en;
            if (ln_en) begin
                rd0 <= rword[0];
                rd1 <= rword[1];
            end
        end
    end
endmodule

// File: rtl/qdr_burst_mem.sv
// Top level: burst memory with a shared, slot-multiplexed address bus,
// separate write and read data ports of two words per clock, and a
// two-cycle read latency with a valid flag.
// Assumes: single clock; double-rate beats arrive as word pairs.
module qdr_burst_mem #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd_sel_n,
    input  logic               wr_sel_n,
    output logic               wr_slot,
    input  logic [8*LANES-1:0] wd0,
    input  logic [8*LANES-1:0] wd1,
    input  logic [LANES-1:0]   wbe0,
    input  logic [LANES-1:0]   wbe1,
    output logic [8*LANES-1:0] rd0,
    output logic [8*LANES-1:0] rd1,
    output logic               rd_valid
);
    logic              rd_take, wr_take;
    logic              cm_en, cm_half, ln_en, ln_half;
    logic [ADDR_W-1:0] cm_addr, ln_addr;

    qdrb_req_ctl u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .slot_o   (wr_slot),
        .rd_take  (rd_take),
        .wr_take  (wr_take)
    );

    qdrb_wr_seq #(.AW(ADDR_W)) u_wseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_take (wr_take),
        .addr    (addr),
        .cm_en   (cm_en),
        .cm_addr (cm_addr),
        .cm_half (cm_half)
    );

    qdrb_rd_pipe #(.AW(ADDR_W)) u_rpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_take (rd_take),
        .addr    (addr),
        .ln_en   (ln_en),
        .ln_addr (ln_addr),
        .ln_half (ln_half)
    );

    qdrb_store #(.AW(ADDR_W), .LANES(LANES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cm_en    (cm_en),
        .cm_addr  (cm_addr),
        .cm_half  (cm_half),
        .wd0      (wd0),
        .wd1      (wd1),
        .wbe0     (wbe0),
        .wbe1     (wbe1),
        .ln_en    (ln_en),
        .ln_addr  (ln_addr),
        .ln_half  (ln_half),
        .rd0      (rd0),
        .rd1      (rd1),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/qdrb_checker.sv
// Port-level timing properties of the burst memory, bound to the top.
module qdrb_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_slot,
    input logic rd_sel_n,
    input logic rd_valid
);
    // R2: the slot bit alternates on every clock once out of reset.
    p_slot_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_slot != $past(wr_slot)));

    // R7: a read taken in a read slot shows valid data after two more edges.
    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_slot && !rd_sel_n) |=> ##2 rd_valid);

    // R3: every output burst traces back to a selected read-slot request.
    p_valid_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!wr_slot && !rd_sel_n, 3));

    // R8: valid comes as at least a pair of cycles.
    p_valid_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);
endmodule

bind qdr_burst_mem qdrb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_slot  (wr_slot),
    .rd_sel_n (rd_sel_n),
    .rd_valid (rd_valid)
);

// File: tb/sim_qdr_burst_mem.sv
module sim_qdr_burst_mem;
    localparam int PERIOD = 10;
    localparam int AW     = 6;
    localparam int LANES  = 2;
    localparam int DW     = 8 * LANES;
    localparam int LINES  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic          wr_slot;
    logic [DW-1:0] wd0 = '0, wd1 = '0;
    logic [LANES-1:0] wbe0 = '0, wbe1 = '0;
    logic [DW-1:0] rd0, rd1;
    logic          rd_valid;

    qdr_burst_mem #(.ADDR_W(AW), .LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .wr_slot(wr_slot), .wd0(wd0), .wd1(wd1),
        .wbe0(wbe0), .wbe1(wbe1), .rd0(rd0), .rd1(rd1), .rd_valid(rd_valid)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct { int a; int due; } rexp_t;
    rexp_t rq[$];

    int checks = 0, errors = 0, cyc = 0;
    bit run = 0, done = 0;
    string tag = "R1";

    logic [DW-1:0]    refm [LINES][4];
    logic [DW-1:0]    nw_d [4];
    logic [LANES-1:0] nw_be [4];
    bit               h0_v = 0, h1_v = 0;
    int               h0_a, h1_a;
    logic [DW-1:0]    h0_d [4], h1_d [4];
    logic [LANES-1:0] h0_be [4], h1_be [4];

    task automatic commit(input int a, input int w, input logic [DW-1:0] d, input logic [LANES-1:0] be);
        for (int l = 0; l < LANES; l++)
            if (be[l]) refm[a][w][l*8 +: 8] = d[l*8 +: 8];
    endtask

    task automatic chk(input string t, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", t, what, got, exp, cyc);
        end
    endtask

    // Driver: one clock of stimulus; records expected reads in the queue.
    task automatic step(input bit rreq, input int ra, input bit wreq, input int wa);
        bit s;
        s = (cyc % 2) == 1;
        chk("R2", "slot", DW'(wr_slot), DW'(s));
        addr     = s ? AW'(wa) : AW'(ra);
        rd_sel_n = !rreq;
        wr_sel_n = !wreq;
        if (h0_v) begin
            wd0 = h0_d[0]; wd1 = h0_d[1]; wbe0 = h0_be[0]; wbe1 = h0_be[1];
        end else if (h1_v) begin
            wd0 = h1_d[2]; wd1 = h1_d[3]; wbe0 = h1_be[2]; wbe1 = h1_be[3];
        end else begin
            wd0 = DW'($urandom); wd1 = DW'($urandom);
            wbe0 = LANES'($urandom); wbe1 = LANES'($urandom);
        end
        @(posedge clk);
        cyc++;
        if (h1_v) begin
            commit(h1_a, 2, h1_d[2], h1_be[2]);
            commit(h1_a, 3, h1_d[3], h1_be[3]);
            h1_v = 0;
        end
        if (h0_v) begin
            commit(h0_a, 0, h0_d[0], h0_be[0]);
            commit(h0_a, 1, h0_d[1], h0_be[1]);
            h1_v = 1; h1_a = h0_a; h1_d = h0_d; h1_be = h0_be;
            h0_v = 0;
        end
        if (s && wreq) begin
            h0_v = 1; h0_a = wa; h0_d = nw_d; h0_be = nw_be;
        end
        if (!s && rreq) rq.push_back('{a: ra, due: cyc + 2});
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic wr(input int a);
        if ((cyc % 2) == 0) step(0, 0, 0, 0);
        step(0, 0, 1, a);
    endtask

    task automatic rd(input int a);
        if ((cyc % 2) == 1) step(0, 0, 0, 0);
        step(1, a, 0, 0);
    endtask

    task automatic full_be();
        for (int w = 0; w < 4; w++) nw_be[w] = '1;
    endtask

    // Monitor: pops expected read pairs and compares with the reference array.
    always @(negedge clk) begin
        if (run && !done) begin
            if (rq.size() > 0 && rq[0].due + 1 == cyc) begin
                chk(tag, "valid pair1 (R8)", DW'(rd_valid), DW'(1));
                chk(tag, "word2 (R7)", rd0, refm[rq[0].a][2]);
                chk(tag, "word3 (R7)", rd1, refm[rq[0].a][3]);
                void'(rq.pop_front());
            end else if (rq.size() > 0 && rq[0].due == cyc) begin
                chk(tag, "valid pair0 (R8)", DW'(rd_valid), DW'(1));
                chk(tag, "word0 (R7)", rd0, refm[rq[0].a][0]);
                chk(tag, "word1 (R7)", rd1, refm[rq[0].a][1]);
            end else begin
                chk(tag, "idle valid (R8)", DW'(rd_valid), DW'(0));
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid in reset", DW'(rd_valid), DW'(0));
        chk("R1", "slot in reset", DW'(wr_slot), DW'(0));
        rst_n = 1'b1;
        run = 1;

        // R5: fill every line with a known pattern
        tag = "R5";
        full_be();
        for (int a = 0; a < LINES; a++) begin
            for (int w = 0; w < 4; w++) nw_d[w] = DW'(16'hA000 + a * 4 + w);
            wr(a);
        end
        idle(4);

        // R7 / R10: back-to-back reads of every line
        tag = "R7";
        for (int a = 0; a < LINES; a++) rd(a);
        idle(4);
        tag = "R10";
        for (int a = LINES - 1; a >= LINES - 8; a--) rd(a);
        idle(4);

        // R6: partial byte enables
        tag = "R6";
        for (int w = 0; w < 4; w++) nw_d[w] = DW'(16'hFFFF - w);
        nw_be[0] = 2'b01; nw_be[1] = 2'b10; nw_be[2] = 2'b00; nw_be[3] = 2'b11;
        wr(5);
        idle(2);
        rd(5);
        idle(4);

        // R3: deselected reads yield no output
        tag = "R3";
        for (int i = 0; i < 6; i++) step(0, 7, 0, 0);
        idle(4);

        // R4: deselected write leaves the line intact
        tag = "R4";
        full_be();
        for (int w = 0; w < 4; w++) nw_d[w] = DW'(16'h1234);
        if ((cyc % 2) == 0) step(0, 0, 0, 0);
        step(0, 0, 0, 9);
        idle(3);
        rd(9);
        idle(4);

        // R2: selects in the wrong slot are ignored
        tag = "R2";
        if ((cyc % 2) == 0) step(0, 0, 0, 0);
        step(1, 11, 0, 0);
        step(0, 0, 1, 11);
        idle(4);
        rd(11);
        idle(4);

        // R9: read, then write to the same line in the next slot
        tag = "R9";
        full_be();
        for (int w = 0; w < 4; w++) nw_d[w] = DW'(16'h5100 + w);
        if ((cyc % 2) == 1) step(0, 0, 0, 0);
        step(1, 10, 0, 0);
        step(0, 0, 1, 10);
        idle(4);
        // write, then read the same line in the next slot
        for (int w = 0; w < 4; w++) nw_d[w] = DW'(16'h6200 + w);
        nw_be[1] = 2'b10;
        wr(12);
        step(1, 12, 0, 0);
        idle(4);

        // R9: dense random traffic over four lines
        for (int i = 0; i < 400; i++) begin
            for (int w = 0; w < 4; w++) begin
                nw_d[w]  = DW'($urandom);
                nw_be[w] = LANES'($urandom);
            end
            step(($urandom % 8) != 0, $urandom % 4, ($urandom % 8) != 0, $urandom % 4);
        end
        idle(6);
        chk("R8", "queue drained", DW'(rq.size()), DW'(0));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R7 watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule